// File: doc/BRIEF.md
# Processor Status Register with RAM Page Selection

This block holds the processor's status byte: carry and zero from the arithmetic unit, the global interrupt enable, the extended register space select and a two-bit paging mode. The status byte is updated from four sources. These are arithmetic flag updates, explicit bitwise flag instructions with an immediate byte, an interrupt-entry clear, and a return-from-interrupt restore of a saved image.

The paging mode decides where the upper RAM address bits come from. For each of the two access kinds, direct and indexed, it selects between page 0 and one of three page pointers: current, index or stack. Interrupt entry clears the whole byte. That drops the paging mode to 00, so every access goes to page 0, and it also masks further interrupts until the flags are restored.

Top module: `cpu_status_unit`

## Requirements
- R1: After a synchronous reset, every bit of `flags_q` is 0.
- R2: When `alu_upd` is high, and no higher-priority source acts, bit 2 takes `alu_carry` and bit 1 takes `alu_zero` on the next edge. All other bits keep their value.
- R3: When `fop_valid` is high, `fop_kind` selects the flag instruction: 00 is AND, 01 is OR, 10 is XOR of the byte with `fop_imm`. Kind 11 leaves the byte unchanged.
- R4: Bits 5 and 3 of `flags_q` always read 0, whatever value any source writes there.
- R5: With paging mode (bits 7:6) at 00, `direct_page` and `indexed_page` are both 0, whatever the pointers hold.
- R6: With mode 01, `direct_page` is 0 and `indexed_page` follows `stk_pg`.
- R7: With mode 10, `direct_page` follows `cur_pg` and `indexed_page` follows `idx_pg`.
- R8: With mode 11, `direct_page` follows `cur_pg` and `indexed_page` follows `stk_pg`.
- R9: `irq_enter` clears the whole byte on the next edge, overriding every other source.
- R10: When a flag instruction and an arithmetic update arrive in the same cycle, the flag instruction result is stored and the arithmetic values are dropped.
- R11: `rti_load` stores `rti_image`, with bits 5 and 3 forced to 0, in one cycle. It takes priority over flag instructions and arithmetic updates.
- R12: `carry_o`, `zero_o`, `irq_enabled_o` and `ext_space_o` equal bits 2, 1, 0 and 4 of `flags_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_upd | input | 1 | Arithmetic flag update strobe |
| alu_carry | input | 1 | New carry value |
| alu_zero | input | 1 | New zero value |
| fop_valid | input | 1 | Flag instruction strobe |
| fop_kind | input | 2 | 00 AND, 01 OR, 10 XOR, 11 no change |
| fop_imm | input | 8 | Immediate operand |
| irq_enter | input | 1 | Interrupt-entry pulse |
| rti_load | input | 1 | Return-from-interrupt restore strobe |
| rti_image | input | 8 | Saved status byte |
| cur_pg | input | 3 | Current page pointer |
| idx_pg | input | 3 | Index page pointer |
| stk_pg | input | 3 | Stack page pointer |
| flags_q | output | 8 | Registered status byte |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| irq_enabled_o | output | 1 | Interrupts allowed |
| ext_space_o | output | 1 | Extended register space selected |
| direct_page | output | 3 | RAM page for direct accesses |
| indexed_page | output | 3 | RAM page for indexed accesses |

## Verification
A flag instruction and an arithmetic update can land in the same cycle. The bench raises both strobes together with conflicting carry and zero values. It then checks that the stored byte is exactly the flag instruction result. Interrupt entry is also raised together with the restore, flag-instruction and arithmetic strobes, and the byte is required to read zero on the following edge.

// File: rtl/flag_pkg.sv
package flag_pkg;
  localparam int FLAG_W = 8;
  localparam int BIT_GIE   = 0;
  localparam int BIT_ZERO  = 1;
  localparam int BIT_CARRY = 2;
  localparam int BIT_EXT   = 4;
  localparam int MODE_LO   = 6;
  localparam logic [FLAG_W-1:0] LIVE_MASK = 8'hD7;

  typedef enum logic [1:0] {
    FOP_AND  = 2'b00,
    FOP_OR   = 2'b01,
    FOP_XOR  = 2'b10,
    FOP_NONE = 2'b11
  } fop_e;

  typedef enum logic [1:0] {
    PG_ZERO    = 2'b00,
    PG_STK_IDX = 2'b01,
    PG_CUR_IDX = 2'b10,
    PG_CUR_STK = 2'b11
  } pgmode_e;
endpackage

// File: rtl/status_core.sv
module status_core
  import flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_upd,
  input  logic              alu_carry,
  input  logic              alu_zero,
  input  logic              fop_valid,
  input  logic [1:0]        fop_kind,
  input  logic [FLAG_W-1:0] fop_imm,
  input  logic              irq_enter,
  input  logic              rti_load,
  input  logic [FLAG_W-1:0] rti_image,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] nxt;

  always_comb begin
    nxt = flags;
    if (irq_enter) begin
      nxt = '0;
    end else if (rti_load) begin
      nxt = rti_image;
    end else if (fop_valid) begin
      case (fop_e'(fop_kind))
        FOP_AND: nxt = flags & fop_imm;
        FOP_OR:  nxt = flags | fop_imm;
        FOP_XOR: nxt = flags ^ fop_imm;
        default: nxt = flags;
      endcase
    end else if (alu_upd) begin
      nxt[BIT_CARRY] = alu_carry;
      nxt[BIT_ZERO]  = alu_zero;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= nxt & LIVE_MASK;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> flags == '0);
  p_resv_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (flags[5] == 1'b0) && (flags[3] == 1'b0));
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (rst)
    irq_enter |=> flags == '0);
  p_rti_load_r11: assert property (@(posedge clk) disable iff (rst)
    (rti_load && !irq_enter) |=> flags == ($past(rti_image) & LIVE_MASK));
  p_alu_r2: assert property (@(posedge clk) disable iff (rst)
    (alu_upd && !fop_valid && !irq_enter && !rti_load) |=>
      (flags[BIT_CARRY] == $past(alu_carry)) && (flags[BIT_ZERO] == $past(alu_zero)));
  p_fop_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (fop_valid && fop_kind == 2'b01 && alu_upd && !irq_enter && !rti_load) |=>
      flags == (($past(flags) | $past(fop_imm)) & LIVE_MASK));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!alu_upd && !fop_valid && !irq_enter && !rti_load) |=> $stable(flags));
endmodule

// File: rtl/page_resolver.sv
module page_resolver
  import flag_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic [PAGE_W-1:0] idx_pg,
  input  logic [PAGE_W-1:0] stk_pg,
  output logic [PAGE_W-1:0] direct_page,
  output logic [PAGE_W-1:0] indexed_page
);
  always_comb begin
    case (pgmode_e'(mode))
      PG_ZERO:    begin direct_page = '0;     indexed_page = '0;     end
      PG_STK_IDX: begin direct_page = '0;     indexed_page = stk_pg; end
      PG_CUR_IDX: begin direct_page = cur_pg; indexed_page = idx_pg; end
      default:    begin direct_page = cur_pg; indexed_page = stk_pg; end
    endcase
  end

  p_mode0_r5: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b00 |-> (direct_page == '0 && indexed_page == '0));
  p_mode1_r6: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b01 |-> (direct_page == '0 && indexed_page == stk_pg));
  p_mode2_r7: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b10 |-> (direct_page == cur_pg && indexed_page == idx_pg));
  p_mode3_r8: assert property (@(posedge clk) disable iff (rst)
    mode == 2'b11 |-> (direct_page == cur_pg && indexed_page == stk_pg));
endmodule

// File: rtl/cpu_status_unit.sv
module cpu_status_unit
  import flag_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_upd,
  input  logic              alu_carry,
  input  logic              alu_zero,
  input  logic              fop_valid,
  input  logic [1:0]        fop_kind,
  input  logic [7:0]        fop_imm,
  input  logic              irq_enter,
  input  logic              rti_load,
  input  logic [7:0]        rti_image,
  input  logic [PAGE_W-1:0] cur_pg,
  input  logic [PAGE_W-1:0] idx_pg,
  input  logic [PAGE_W-1:0] stk_pg,
  output logic [7:0]        flags_q,
  output logic              carry_o,
  output logic              zero_o,
  output logic              irq_enabled_o,
  output logic              ext_space_o,
  output logic [PAGE_W-1:0] direct_page,
  output logic [PAGE_W-1:0] indexed_page
);
  logic [FLAG_W-1:0] flags;

  status_core u_core (
    .clk(clk), .rst(rst),
    .alu_upd(alu_upd), .alu_carry(alu_carry), .alu_zero(alu_zero),
    .fop_valid(fop_valid), .fop_kind(fop_kind), .fop_imm(fop_imm),
    .irq_enter(irq_enter), .rti_load(rti_load), .rti_image(rti_image),
    .flags(flags)
  );

  page_resolver #(.PAGE_W(PAGE_W)) u_pages (
    .clk(clk), .rst(rst),
    .mode(flags[MODE_LO+1:MODE_LO]),
    .cur_pg(cur_pg), .idx_pg(idx_pg), .stk_pg(stk_pg),
    .direct_page(direct_page), .indexed_page(indexed_page)
  );

  assign flags_q       = flags;
  assign carry_o       = flags[BIT_CARRY];
  assign zero_o        = flags[BIT_ZERO];
  assign irq_enabled_o = flags[BIT_GIE];
  assign ext_space_o   = flags[BIT_EXT];
endmodule

// File: tb/tb_cpu_status_unit.sv
module tb_cpu_status_unit;
  logic clk = 0;
  logic rst;
  logic alu_upd, alu_carry, alu_zero, fop_valid, irq_enter, rti_load;
  logic [1:0] fop_kind;
  logic [7:0] fop_imm, rti_image, flags_q;
  logic [2:0] cur_pg, idx_pg, stk_pg, direct_page, indexed_page;
  logic carry_o, zero_o, irq_enabled_o, ext_space_o;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  cpu_status_unit dut (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    alu_upd = 0; alu_carry = 0; alu_zero = 0; fop_valid = 0; fop_kind = 2'b11;
    fop_imm = 0; irq_enter = 0; rti_load = 0; rti_image = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    @(negedge clk); idle();
  endtask

  task automatic fop(input logic [1:0] k, input logic [7:0] imm);
    fop_valid = 1; fop_kind = k; fop_imm = imm; step();
  endtask

  task automatic restore(input logic [7:0] img);
    rti_load = 1; rti_image = img; step();
  endtask

  task automatic t_reset();
    check("R1 flags after reset", flags_q, 8'h00);
    check("R5 pages after reset", {direct_page, indexed_page}, 0);
  endtask

  task automatic t_alu();
    alu_upd = 1; alu_carry = 1; alu_zero = 0; step();
    check("R2 carry set", flags_q, 8'h04);
    check("R12 carry_o", carry_o, 1);
    alu_upd = 1; alu_carry = 0; alu_zero = 1; step();
    check("R2 zero set", flags_q, 8'h02);
    check("R12 zero_o", zero_o, 1);
  endtask

  task automatic t_fop();
    fop(2'b01, 8'hFF);
    check("R3 OR, R4 reserved", flags_q, 8'hD7);
    check("R12 gie/ext", {irq_enabled_o, ext_space_o}, 2'b11);
    fop(2'b00, 8'h3C);
    check("R3 AND", flags_q, 8'h14);
    fop(2'b10, 8'hC3);
    check("R3 XOR", flags_q, 8'hD7);
    fop(2'b11, 8'h00);
    check("R3 kind 11 no change", flags_q, 8'hD7);
    fop(2'b10, 8'h28);
    check("R4 XOR on reserved", flags_q, 8'hD7);
  endtask

  task automatic t_pages();
    cur_pg = 3'd3; idx_pg = 3'd5; stk_pg = 3'd6;
    restore(8'h00); #1;
    check("R5 mode00", {direct_page, indexed_page}, {3'd0, 3'd0});
    restore(8'h40); #1;
    check("R6 mode01", {direct_page, indexed_page}, {3'd0, 3'd6});
    restore(8'h80); #1;
    check("R7 mode10", {direct_page, indexed_page}, {3'd3, 3'd5});
    restore(8'hC0); #1;
    check("R8 mode11", {direct_page, indexed_page}, {3'd3, 3'd6});
    stk_pg = 3'd1; #1;
    check("R8 mode11 follows stk", indexed_page, 3'd1);
  endtask

  task automatic t_same_cycle();
    restore(8'h00);
    fop_valid = 1; fop_kind = 2'b01; fop_imm = 8'h01;
    alu_upd = 1; alu_carry = 1; alu_zero = 1; step();
    check("R10 fop beats alu", flags_q, 8'h01);
    rti_load = 1; rti_image = 8'hFF; fop_valid = 1; fop_kind = 2'b01;
    fop_imm = 8'h04; alu_upd = 1; alu_carry = 0; alu_zero = 0; step();
    check("R11 rti beats fop", flags_q, 8'hD7);
    irq_enter = 1; rti_load = 1; rti_image = 8'hFF; fop_valid = 1;
    fop_kind = 2'b01; fop_imm = 8'hFF; alu_upd = 1; alu_carry = 1; step();
    check("R9 irq clears all", flags_q, 8'h00);
    check("R9 pages to 0", {direct_page, indexed_page}, 0);
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 5000) begin
        n_fail++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    idle(); cur_pg = 0; idx_pg = 0; stk_pg = 0;
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0; #1;
    t_reset();
    @(negedge clk);
    t_alu();
    t_fop();
    t_pages();
    t_same_cycle();
    restore(8'hFF);
    check("R11 image masked", flags_q, 8'hD7);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule